// File: doc/BRIEF.md
# LCD Raster Timing Controller

This block generates the raster timing for a parallel RGB panel. A processor programs it through a 32-bit register port with word-aligned byte addresses. It sets the active area, the line and frame totals, where each sync pulse sits and how wide it is, the sync polarity and which panel outputs are driven. Once both the global enable and the channel enable are set, two counters walk the frame. The block then produces the pixel position, data-enable and horizontal and vertical sync, all registered.

Sync placement is not programmed as a true back porch. Each timing word stores a porch equal to the total minus the sync start, so the pulse begins that many clocks (or lines) before the end of the line (or frame). A polarity bit that is set makes the matching sync active low. An interrupt flags the first clock below the active area and the first clock of each frame. Software clears a flag by writing 0 to it. The outputs start out high-impedance until software clears the tristate mask.

Top module: `lcdt_timing_ctrl`

## Requirements
- R1: After reset, the control word (0x00), the interrupt word (0x04) and the channel word (0x08) read 0. The tristate word (0x20) reads 0xFFFFFFFF and every bit of `lcd_oe` is 0.
- R2: Unless bit 0 of 0x00 (global enable) and bit 0 of 0x08 (channel enable) are both 1, `pix_x` and `pix_y` stay 0, `lcd_de` stays 0, and each sync output holds its inactive level.
- R3: While running, `pix_x` counts 0 up to HTOTAL-1 and then wraps to 0. `pix_y` steps by one at each wrap of `pix_x` and wraps to 0 after VTOTAL-1. HTOTAL is bits [11:0] of 0x10 and VTOTAL is bits [11:0] of 0x14.
- R4: `lcd_de` is 1 exactly when `pix_x` < WIDTH and `pix_y` < HEIGHT. WIDTH is bits [11:0] of 0x0C and HEIGHT is bits [27:16] of 0x0C.
- R5: The horizontal sync is asserted for `pix_x` in [HTOTAL-HPORCH, HTOTAL-HPORCH+HSW). HPORCH is bits [27:16] of 0x10 and HSW is bits [11:0] of 0x18.
- R6: The vertical sync is asserted for whole lines with `pix_y` in [VTOTAL-VPORCH, VTOTAL-VPORCH+VSW). VPORCH is bits [27:16] of 0x14 and VSW is bits [27:16] of 0x18.
- R7: With bit 0 (hsync) or bit 1 (vsync) of 0x1C clear, that sync is active high. With the bit set, it is active low.
- R8: Status bit 8 of 0x04 sets on the clock where the position is (0, HEIGHT). Status bit 9 sets at (0, 0). Writing 0 to a status bit clears it, and writing 1 leaves it unchanged.
- R9: `irq` is 1, one clock after the condition, when any status bit is set together with its enable bit. Bit 0 of 0x04 enables status bit 8 and bit 1 enables status bit 9.
- R10: `lcd_oe` bit k is the inverse of bit k of 0x20, where bit 0 is hsync, bit 1 is vsync and bit 2 is data-enable.
- R11: Reads return data on the clock after `reg_rd`. Only the listed fields are stored, so writing all ones to 0x0C reads back 0x0FFF0FFF. Unmapped words, 0x800 among them, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and register clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address, bits [1:0] ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the clock after reg_rd |
| pix_x | output | 12 | Horizontal position |
| pix_y | output | 12 | Vertical position |
| lcd_de | output | 1 | Data-enable |
| lcd_hsync | output | 1 | Horizontal sync, polarity applied |
| lcd_vsync | output | 1 | Vertical sync, polarity applied |
| lcd_oe | output | 3 | Output drive enables: hsync, vsync, de |
| irq | output | 1 | Interrupt request |

## Verification
The raster is swept for two full frames under three small geometries. In the first, both syncs are active high and start mid-line. In the second, the polarity is inverted and the pulses are wider. In the third, the sync start falls on position zero. Together they separate off-by-one errors in the wrap points, in the porch subtraction and in the pulse length from polarity mistakes, and every cycle is compared against position arithmetic. The interrupt is checked with its enable clear and set, with a write of 1 and a write of 0 to the status bits, and at the exact line where blanking begins. Separate runs show that a lone channel enable produces no activity and that the tristate mask drives each pin individually.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  // word indices (byte address / 4)
  localparam logic [9:0] IDX_CTRL = 10'd0;
  localparam logic [9:0] IDX_IRQ  = 10'd1;
  localparam logic [9:0] IDX_CHAN = 10'd2;
  localparam logic [9:0] IDX_SIZE = 10'd3;
  localparam logic [9:0] IDX_HTIM = 10'd4;
  localparam logic [9:0] IDX_VTIM = 10'd5;
  localparam logic [9:0] IDX_SYNC = 10'd6;
  localparam logic [9:0] IDX_POL  = 10'd7;
  localparam logic [9:0] IDX_TRI  = 10'd8;
  // field placement inside a word
  localparam int unsigned HI_LSB  = 16;
  localparam int unsigned ST_LSB  = 8;
  localparam int unsigned NSRC    = 2;
  // output pin positions in the tristate mask
  localparam int unsigned PIN_HS  = 0;
  localparam int unsigned PIN_VS  = 1;
  localparam int unsigned PIN_DE  = 2;
  localparam int unsigned NPIN    = 3;
endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            glb_en,
  output logic            chan_en,
  output logic [CW-1:0]   act_w,
  output logic [CW-1:0]   act_h,
  output logic [CW-1:0]   h_tot,
  output logic [CW-1:0]   h_porch,
  output logic [CW-1:0]   v_tot,
  output logic [CW-1:0]   v_porch,
  output logic [CW-1:0]   hs_w,
  output logic [CW-1:0]   vs_w,
  output logic [1:0]      pol_inv,
  output logic [NPIN-1:0] tri_mask,
  output logic [NSRC-1:0] irq_en,
  output logic            irq_wr,
  output logic [NSRC-1:0] irq_keep,
  input  logic [NSRC-1:0] irq_st
);
  localparam int unsigned IW = AW - 2;

  logic [IW-1:0] idx;
  logic [DW-1:0] tri_q;
  logic [DW-1:0] rd_mux;

  assign idx      = addr[AW-1:2];
  assign irq_wr   = wr_en && (idx == IDX_IRQ[IW-1:0]);
  assign irq_keep = wdata[ST_LSB +: NSRC];
  assign tri_mask = tri_q[NPIN-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en  <= 1'b0;
      chan_en <= 1'b0;
      irq_en  <= '0;
      act_w   <= '0;
      act_h   <= '0;
      h_tot   <= '0;
      h_porch <= '0;
      v_tot   <= '0;
      v_porch <= '0;
      hs_w    <= '0;
      vs_w    <= '0;
      pol_inv <= '0;
      tri_q   <= '1;
    end else if (wr_en) begin
      case (idx)
        IDX_CTRL[IW-1:0]: glb_en  <= wdata[0];
        IDX_IRQ[IW-1:0]:  irq_en  <= wdata[NSRC-1:0];
        IDX_CHAN[IW-1:0]: chan_en <= wdata[0];
        IDX_SIZE[IW-1:0]: begin
          act_w <= wdata[CW-1:0];
          act_h <= wdata[HI_LSB +: CW];
        end
        IDX_HTIM[IW-1:0]: begin
          h_tot   <= wdata[CW-1:0];
          h_porch <= wdata[HI_LSB +: CW];
        end
        IDX_VTIM[IW-1:0]: begin
          v_tot   <= wdata[CW-1:0];
          v_porch <= wdata[HI_LSB +: CW];
        end
        IDX_SYNC[IW-1:0]: begin
          hs_w <= wdata[CW-1:0];
          vs_w <= wdata[HI_LSB +: CW];
        end
        IDX_POL[IW-1:0]:  pol_inv <= wdata[1:0];
        IDX_TRI[IW-1:0]:  tri_q   <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (idx)
      IDX_CTRL[IW-1:0]: rd_mux[0] = glb_en;
      IDX_IRQ[IW-1:0]: begin
        rd_mux[NSRC-1:0]        = irq_en;
        rd_mux[ST_LSB +: NSRC]  = irq_st;
      end
      IDX_CHAN[IW-1:0]: rd_mux[0] = chan_en;
      IDX_SIZE[IW-1:0]: begin
        rd_mux[CW-1:0]       = act_w;
        rd_mux[HI_LSB +: CW] = act_h;
      end
      IDX_HTIM[IW-1:0]: begin
        rd_mux[CW-1:0]       = h_tot;
        rd_mux[HI_LSB +: CW] = h_porch;
      end
      IDX_VTIM[IW-1:0]: begin
        rd_mux[CW-1:0]       = v_tot;
        rd_mux[HI_LSB +: CW] = v_porch;
      end
      IDX_SYNC[IW-1:0]: begin
        rd_mux[CW-1:0]       = hs_w;
        rd_mux[HI_LSB +: CW] = vs_w;
      end
      IDX_POL[IW-1:0]:  rd_mux[1:0] = pol_inv;
      IDX_TRI[IW-1:0]:  rd_mux = tri_q;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R1: tristate mask never loses bits except through a register write
  p_tri_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(tri_q));
endmodule

// File: rtl/lcdt_raster.sv
module lcdt_raster #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] act_w,
  input  logic [CW-1:0] act_h,
  input  logic [CW-1:0] h_tot,
  input  logic [CW-1:0] h_porch,
  input  logic [CW-1:0] v_tot,
  input  logic [CW-1:0] v_porch,
  input  logic [CW-1:0] hs_w,
  input  logic [CW-1:0] vs_w,
  input  logic [1:0]    pol_inv,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic          de,
  output logic          hsync,
  output logic          vsync,
  output logic          blank_evt,
  output logic          frame_evt
);
  logic [CW-1:0] hc, vc;
  logic          line_end, frame_end;
  logic [CW:0]   hs_start, vs_start;
  logic          hs_on, vs_on, de_c;

  assign line_end  = (hc == h_tot - 1'b1);
  assign frame_end = (vc == v_tot - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hc <= '0;
      vc <= '0;
    end else if (line_end) begin
      hc <= '0;
      vc <= frame_end ? '0 : vc + 1'b1;
    end else begin
      hc <= hc + 1'b1;
    end
  end

  // sync starts (total - porch) positions into the line / frame
  assign hs_start = {1'b0, h_tot} - {1'b0, h_porch};
  assign vs_start = {1'b0, v_tot} - {1'b0, v_porch};
  assign hs_on = run && ({1'b0, hc} >= hs_start) &&
                 ({1'b0, hc} < hs_start + {1'b0, hs_w});
  assign vs_on = run && ({1'b0, vc} >= vs_start) &&
                 ({1'b0, vc} < vs_start + {1'b0, vs_w});
  assign de_c  = run && (hc < act_w) && (vc < act_h);

  assign blank_evt = run && (hc == '0) && (vc == act_h);
  assign frame_evt = run && (hc == '0) && (vc == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_x <= '0;
      pix_y <= '0;
      de    <= 1'b0;
      hsync <= 1'b0;
      vsync <= 1'b0;
    end else begin
      pix_x <= hc;
      pix_y <= vc;
      de    <= de_c;
      hsync <= hs_on ^ pol_inv[0];
      vsync <= vs_on ^ pol_inv[1];
    end
  end

  // R2: a stopped generator parks its counters at the origin
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (hc == '0 && vc == '0));
  // R2: no data-enable without a running generator
  p_de_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> !de);
  // R3: the column counter only steps or wraps
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    run |=> (hc == '0 || hc == $past(hc) + 1'b1));
  // R6: vertical sync only changes on a line boundary
  p_vs_line_r6: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && pix_x != '0 && $stable(pol_inv)) |-> $stable(vsync));
endmodule

// File: rtl/lcdt_irq.sv
module lcdt_irq #(
  parameter int unsigned NS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] evt,
  input  logic          wr,
  input  logic [NS-1:0] keep,
  input  logic [NS-1:0] en,
  output logic [NS-1:0] status,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & (wr ? keep : {NS{1'b1}})) | evt;
      irq    <= |(status & en);
    end
  end

  for (genvar i = 0; i < NS; i++) begin : g_chk
    // R8: a flag drops only after software wrote 0 to it
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(status[i]) |-> $past(wr && !keep[i]));
    // R8: a flag rises only after its event
    p_set_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(status[i]) |-> $past(evt[i]));
  end

  // R9: the request follows an enabled flag by one clock
  p_req_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((status & en) != '0));
endmodule

// File: rtl/lcdt_timing_ctrl.sv
module lcdt_timing_ctrl
  import lcdt_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic [CW-1:0]   pix_x,
  output logic [CW-1:0]   pix_y,
  output logic            lcd_de,
  output logic            lcd_hsync,
  output logic            lcd_vsync,
  output logic [NPIN-1:0] lcd_oe,
  output logic            irq
);
  logic            glb_en, chan_en, run;
  logic [CW-1:0]   act_w, act_h, h_tot, h_porch, v_tot, v_porch, hs_w, vs_w;
  logic [1:0]      pol_inv;
  logic [NPIN-1:0] tri_mask;
  logic [NSRC-1:0] irq_en, irq_keep, irq_st, evt;
  logic            irq_wr, blank_evt, frame_evt;

  lcdt_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .glb_en(glb_en), .chan_en(chan_en),
    .act_w(act_w), .act_h(act_h), .h_tot(h_tot), .h_porch(h_porch),
    .v_tot(v_tot), .v_porch(v_porch), .hs_w(hs_w), .vs_w(vs_w),
    .pol_inv(pol_inv), .tri_mask(tri_mask), .irq_en(irq_en), .irq_wr(irq_wr),
    .irq_keep(irq_keep), .irq_st(irq_st)
  );

  assign run = glb_en & chan_en;

  lcdt_raster #(.CW(CW)) u_raster (
    .clk(clk), .rst(rst), .run(run), .act_w(act_w), .act_h(act_h),
    .h_tot(h_tot), .h_porch(h_porch), .v_tot(v_tot), .v_porch(v_porch),
    .hs_w(hs_w), .vs_w(vs_w), .pol_inv(pol_inv), .pix_x(pix_x), .pix_y(pix_y),
    .de(lcd_de), .hsync(lcd_hsync), .vsync(lcd_vsync),
    .blank_evt(blank_evt), .frame_evt(frame_evt)
  );

  assign evt = {frame_evt, blank_evt};

  lcdt_irq #(.NS(NSRC)) u_irq (
    .clk(clk), .rst(rst), .evt(evt), .wr(irq_wr), .keep(irq_keep),
    .en(irq_en), .status(irq_st), .irq(irq)
  );

  assign lcd_oe = ~tri_mask;

  // R10: every output drive enable is off until software writes the mask
  p_oe_reset_r10: assert property (@(posedge clk)
    $past(rst) && !reg_wr |=> lcd_oe == '0);
endmodule

// File: tb/test_lcdt_timing_ctrl.sv
module test_lcdt_timing_ctrl;
  localparam int unsigned CW = 12;
  localparam logic [11:0] A_CTRL = 12'h000, A_IRQ = 12'h004, A_CHAN = 12'h008,
    A_SIZE = 12'h00C, A_HTIM = 12'h010, A_VTIM = 12'h014, A_SYNC = 12'h018,
    A_POL = 12'h01C, A_TRI = 12'h020;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [CW-1:0] pix_x, pix_y;
  logic lcd_de, lcd_hsync, lcd_vsync, irq;
  logic [2:0] lcd_oe;

  int vectors = 0, errs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lcdt_timing_ctrl i_lcdt_timing_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_x(pix_x), .pix_y(pix_y),
    .lcd_de(lcd_de), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
    .lcd_oe(lcd_oe), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_pos(input int x, input int y);
    do @(negedge clk); while (!(pix_x == x && pix_y == y));
  endtask

  task automatic prog(input int w, h, ht, hp, hsw, vt, vp, vsw, pol);
    wr(A_CHAN, 0);
    wr(A_SIZE, (h << 16) | w);
    wr(A_HTIM, (hp << 16) | ht);
    wr(A_VTIM, (vp << 16) | vt);
    wr(A_SYNC, (vsw << 16) | hsw);
    wr(A_POL, pol);
    wr(A_CTRL, 1);
    wr(A_CHAN, 1);
  endtask

  // two full frames, every cycle compared against position arithmetic
  task automatic sweep(input int w, h, ht, hp, hsw, vt, vp, vsw, pol);
    int px, py, ex, ey, hs, vs, nde, n;
    bit hact, vact;
    prog(w, h, ht, hp, hsw, vt, vp, vsw, pol);
    wait_pos(1, 0);
    hs = ht - hp; vs = vt - vp; nde = 0; n = 2 * ht * vt;
    px = 0; py = 0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        ex = (px == ht - 1) ? 0 : px + 1;
        ey = (px == ht - 1) ? ((py == vt - 1) ? 0 : py + 1) : py;
        chk(pix_x == ex && pix_y == ey, "R3", "position",
            {pix_x, pix_y}, (ex << 12) | ey);
      end
      px = pix_x; py = pix_y;
      chk(lcd_de == (px < w && py < h), "R4", "data-enable", lcd_de, px < w && py < h);
      hact = (px >= hs) && (px < hs + hsw);
      vact = (py >= vs) && (py < vs + vsw);
      chk(lcd_hsync == (hact ^ pol[0]), "R5/R7", "hsync", lcd_hsync, hact ^ pol[0]);
      chk(lcd_vsync == (vact ^ pol[1]), "R6/R7", "vsync", lcd_vsync, vact ^ pol[1]);
      if (lcd_de) nde++;
      @(negedge clk);
    end
    chk(nde == 2 * w * h, "R4", "active clocks in two frames", nde, 2 * w * h);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      report();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, d); chk(d == 0, "R1", "control word", d, 0);
    rd(A_IRQ, d);  chk(d == 0, "R1", "interrupt word", d, 0);
    rd(A_CHAN, d); chk(d == 0, "R1", "channel word", d, 0);
    rd(A_TRI, d);  chk(d == 32'hFFFF_FFFF, "R1", "tristate word", d, 32'hFFFF_FFFF);
    chk(lcd_oe == 3'b000, "R1", "drive enables", lcd_oe, 0);

    // R11 field storage and unmapped words
    wr(A_SIZE, 32'hFFFF_FFFF);
    rd(A_SIZE, d); chk(d == 32'h0FFF_0FFF, "R11", "size readback", d, 32'h0FFF_0FFF);
    rd(12'h800, d); chk(d == 0, "R11", "word 0x800", d, 0);
    rd(12'h07C, d); chk(d == 0, "R11", "unmapped word", d, 0);

    // R10 tristate mask
    wr(A_TRI, 0);
    chk(lcd_oe == 3'b111, "R10", "all driven", lcd_oe, 3'b111);
    wr(A_TRI, 32'h5);
    chk(lcd_oe == 3'b010, "R10", "only vsync driven", lcd_oe, 3'b010);

    // R2 channel enable alone gives no activity
    prog(5, 3, 9, 3, 2, 6, 2, 1, 0);
    wr(A_CTRL, 0);
    repeat (20) @(negedge clk);
    chk(pix_x == 0 && pix_y == 0, "R2", "position held", {pix_x, pix_y}, 0);
    chk(lcd_de == 0, "R2", "data-enable idle", lcd_de, 0);
    chk(lcd_hsync == 0 && lcd_vsync == 0, "R2", "syncs inactive",
        {lcd_hsync, lcd_vsync}, 0);

    // R3-R7: mid-line sync, active high
    sweep(5, 3, 9, 3, 2, 6, 2, 1, 0);

    // R8/R9 interrupt behaviour on the running raster
    wr(A_IRQ, 0);
    repeat (70) @(negedge clk);
    rd(A_IRQ, d); chk(d == 32'h300, "R8", "both flags set", d, 32'h300);
    chk(irq == 0, "R9", "masked request", irq, 0);
    wr(A_IRQ, 32'h300);
    rd(A_IRQ, d); chk(d == 32'h300, "R8", "write 1 keeps flags", d, 32'h300);
    wr(A_IRQ, 32'h301);
    repeat (2) @(negedge clk);
    chk(irq == 1, "R9", "enabled request", irq, 1);
    wait_pos(2, 0);
    wr(A_IRQ, 32'h201);
    repeat (2) @(negedge clk);
    chk(irq == 0, "R8", "request after clear", irq, 0);
    rd(A_IRQ, d); chk(d == 32'h201, "R8", "blank flag cleared", d, 32'h201);
    wait_pos(8, 2);
    chk(irq == 0, "R8", "no request before blanking", irq, 0);
    wait_pos(2, 3);
    chk(irq == 1, "R8", "request at blank start", irq, 1);
    wr(A_IRQ, 0);

    // R3-R7: inverted polarity, wider pulses
    sweep(7, 4, 10, 4, 3, 7, 3, 2, 3);
    // R5/R6 boundary: sync begins at position zero, hsync inverted only
    sweep(3, 2, 6, 6, 1, 5, 5, 1, 1);

    done = 1;
    report();
  end
endmodule